// File: doc/BRIEF.md
# Page-Relative Load Address Unit

This block forms the effective address for the load path of a 16-bit, word-addressed processor, and performs the memory reads that each load form needs. A request carries the incremented program counter, the instruction word and a base register value taken from the register file. The block then produces one destination register write and a one-cycle completion pulse.

There are four addressing forms:

- **Page form.** The page bits of the program counter are joined with a 9-bit offset from the instruction, and that address itself is the result.
- **Direct form.** The same address is read once.
- **Indirect form.** The word read at that address is used as a second address, and that second address is read.
- **Base form.** A zero-extended 6-bit index is added to the base register value, and the sum is read.

Every address passes through an internal address register (MAR) before the memory is asked. Every returned word lands in an internal data register (MDR) before it is written back.

The sequencer has seven named states:

| State | What happens there |
|---|---|
| IDLE | Waits for a request. |
| CALC | Loads MAR with the formed address. |
| RD1 | First memory read; waits for valid. |
| REDIR | Moves the fetched pointer into MAR (indirect form only). |
| RD2 | Second memory read; waits for valid. |
| WRITE | Destination register strobe. |
| DONE | Completion pulse. |

The transitions are:

- IDLE→CALC on an accepted request.
- CALC→WRITE for the page form.
- CALC→RD1 for the other forms.
- RD1→REDIR on valid in the indirect form.
- RD1→WRITE on valid in the direct and base forms.
- REDIR→RD2.
- RD2→WRITE on valid.
- WRITE→DONE.
- DONE→IDLE.

Top module: `ea_load_unit`

## Requirements
- R1: After reset, `busy`, `mem_req`, `wr_en` and `done` are all low.
- R2: With `mode`=0 (page form), the write data is {pc[15:9], instr[8:0]} and no memory request is made.
- R3: With `mode`=1 (direct form), exactly one read is issued at {pc[15:9], instr[8:0]}, and the word returned is written.
- R4: With `mode`=2 (indirect form), two reads are issued: the first at {pc[15:9], instr[8:0]}, the second at the word the first returned. The second word is written.
- R5: With `mode`=3 (base form), one read is issued at (base + zero-extended instr[5:0]) mod 2^16, and the returned word is written. Bit 5 of the index never makes the index negative.
- R6: The destination register number on `wr_dst` is instr[11:9] of the accepted request.
- R7: Once `mem_req` is raised, it stays high with `mem_addr` unchanged until a cycle in which `mem_valid` is high. Any memory latency is accepted.
- R8: `wr_en` is high for exactly one cycle per request, and `done` is high for exactly the one cycle that follows it.
- R9: A `start` pulse while `busy` is high is ignored: it causes no extra read and no extra write, and it does not alter the result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| mode | input | 2 | 0 page, 1 direct, 2 indirect, 3 base |
| pc | input | 16 | Incremented program counter |
| instr | input | 16 | Instruction word |
| base_val | input | 16 | Base register value |
| busy | output | 1 | High from acceptance through the completion pulse |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Read address (MAR) |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| wr_en | output | 1 | Destination write strobe |
| wr_dst | output | 3 | Destination register number |
| wr_data | output | 16 | Destination write data (MDR) |
| done | output | 1 | Completion pulse |

## Verification
A wrong state shows up at the ports within a few cycles:

- A skipped REDIR puts the pointer address, not the pointed-to word, on the write port.
- A missed CALC-to-WRITE shortcut shows up as a read address the scoreboard never expected.
- A sequencer that leaves a read state early drops `mem_req` before valid, which the handshake monitor sees on the next clock.
- Sign extension of the index, or an addition used in place of the page join, is exposed at the read address on the first request with bit 5 set or with a carry.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int EA_W = 16;

    typedef enum logic [1:0] {
        EA_PAGE     = 2'd0,
        EA_DIRECT   = 2'd1,
        EA_INDIRECT = 2'd2,
        EA_BASE     = 2'd3
    } ea_mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CALC,
        S_RD1,
        S_REDIR,
        S_RD2,
        S_WRITE,
        S_DONE
    } ea_state_t;

endpackage

// File: rtl/ea_req_latch.sv
module ea_req_latch #(
    parameter int W     = 16,
    parameter int OFF_W = 9,
    parameter int DST_W = 3,
    parameter int DST_LO = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  ea_pkg::ea_mode_t     mode_i,
    input  logic [W-1:0]         pc_i,
    input  logic [W-1:0]         instr_i,
    input  logic [W-1:0]         base_i,
    output ea_pkg::ea_mode_t     mode_q,
    output logic [W-1:OFF_W]     page_q,
    output logic [OFF_W-1:0]     off_q,
    output logic [W-1:0]         base_q,
    output logic [DST_W-1:0]     dst_q
);
    import ea_pkg::*;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= EA_PAGE;
            page_q <= '0;
            off_q  <= '0;
            base_q <= '0;
            dst_q  <= '0;
        end else if (load) begin
            mode_q <= mode_i;
            page_q <= pc_i[W-1:OFF_W];
            off_q  <= instr_i[OFF_W-1:0];
            base_q <= base_i;
            dst_q  <= instr_i[DST_LO +: DST_W];
        end
    end

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen #(
    parameter int W     = 16,
    parameter int OFF_W = 9,
    parameter int IDX_W = 6
) (
    input  ea_pkg::ea_mode_t     mode,
    input  logic [W-1:OFF_W]     page,
    input  logic [OFF_W-1:0]     off,
    input  logic [W-1:0]         base,
    output logic [W-1:0]         ea
);
    import ea_pkg::*;

    localparam int PAD_W = W - IDX_W;

    logic [W-1:0] page_addr;
    logic [W-1:0] idx_ext;
    logic [W-1:0] base_sum;

    assign page_addr = {page, off};
    assign idx_ext   = {{PAD_W{1'b0}}, off[IDX_W-1:0]};
    assign base_sum  = base + idx_ext;

    always_comb begin
        unique case (mode)
            EA_BASE: ea = base_sum;
            default: ea = page_addr;
        endcase
    end

endmodule

// File: rtl/ea_seq.sv
module ea_seq #(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  ea_pkg::ea_mode_t     mode_q,
    input  logic [W-1:0]         ea,
    input  logic                 mem_valid,
    input  logic [W-1:0]         mem_rdata,
    output logic                 idle,
    output logic                 mem_req,
    output logic [W-1:0]         mem_addr,
    output logic                 wr_en,
    output logic [W-1:0]         wr_data,
    output logic                 done
);
    import ea_pkg::*;

    ea_state_t state, nxt;
    logic [W-1:0] mar, mdr;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_CALC;
            S_CALC:  nxt = (mode_q == EA_PAGE) ? S_WRITE : S_RD1;
            S_RD1:   if (mem_valid) nxt = (mode_q == EA_INDIRECT) ? S_REDIR : S_WRITE;
            S_REDIR: nxt = S_RD2;
            S_RD2:   if (mem_valid) nxt = S_WRITE;
            S_WRITE: nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
            mdr <= '0;
        end else begin
            unique case (state)
                S_CALC: begin
                    mar <= ea;
                    if (mode_q == EA_PAGE) mdr <= ea;
                end
                S_RD1, S_RD2: if (mem_valid) mdr <= mem_rdata;
                S_REDIR: mar <= mdr;
                default: ;
            endcase
        end
    end

    always_comb begin
        idle    = (state == S_IDLE);
        mem_req = (state == S_RD1) || (state == S_RD2);
        wr_en   = (state == S_WRITE);
        done    = (state == S_DONE);
    end

    assign mem_addr = mar;
    assign wr_data  = mdr;

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    assert_done_follows_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (done && !wr_en));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_page_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && mode_q == EA_PAGE) |-> !mem_req);

    assert_redir_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REDIR) |=> (mem_addr == $past(wr_data)));

endmodule

// File: rtl/ea_load_unit.sv
module ea_load_unit #(
    parameter int W      = 16,
    parameter int OFF_W  = 9,
    parameter int IDX_W  = 6,
    parameter int DST_W  = 3,
    parameter int DST_LO = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     instr,
    input  logic [W-1:0]     base_val,
    output logic             busy,
    output logic             mem_req,
    output logic [W-1:0]     mem_addr,
    input  logic             mem_valid,
    input  logic [W-1:0]     mem_rdata,
    output logic             wr_en,
    output logic [DST_W-1:0] wr_dst,
    output logic [W-1:0]     wr_data,
    output logic             done
);
    import ea_pkg::*;

    logic             idle;
    logic             load;
    ea_mode_t         mode_q;
    logic [W-1:OFF_W] page_q;
    logic [OFF_W-1:0] off_q;
    logic [W-1:0]     base_q;
    logic [W-1:0]     ea;

    assign load = start && idle;
    assign busy = !idle;

    ea_req_latch #(.W(W), .OFF_W(OFF_W), .DST_W(DST_W), .DST_LO(DST_LO)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .mode_i  (ea_mode_t'(mode)),
        .pc_i    (pc),
        .instr_i (instr),
        .base_i  (base_val),
        .mode_q  (mode_q),
        .page_q  (page_q),
        .off_q   (off_q),
        .base_q  (base_q),
        .dst_q   (wr_dst)
    );

    ea_addr_gen #(.W(W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_agen (
        .mode (mode_q),
        .page (page_q),
        .off  (off_q),
        .base (base_q),
        .ea   (ea)
    );

    ea_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_q    (mode_q),
        .ea        (ea),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .idle      (idle),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .done      (done)
    );

    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(wr_dst));

    assert_wr_dst_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(wr_dst));

endmodule

// File: tb/tb_ea_load_unit.sv
module tb_ea_load_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [15:0] pc = '0, instr = '0, base_val = '0;
    logic        busy, mem_req, wr_en, done;
    logic [15:0] mem_addr, wr_data;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [2:0]  wr_dst;

    int tests = 0;
    int fails = 0;
    int lat = 0;
    int cycles = 0;
    bit finished = 0;

    logic [15:0] exp_rd_addr[$];
    logic [18:0] exp_wr[$];
    string       exp_tag[$];

    always #10 clk = ~clk;

    ea_load_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc(pc),
        .instr(instr), .base_val(base_val), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_dst(wr_dst), .wr_data(wr_data), .done(done)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        return ({a[6:0], a[15:7]} ^ 16'hC3A5) + 16'h0101;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model and read scoreboard (R3 R4 R5 R7)
    int  cnt = 0;
    bit  pend = 0;
    logic [15:0] pend_addr = '0;
    always @(negedge clk) begin
        mem_valid <= 1'b0;
        if (rst_n && mem_req) begin
            if (pend) check(mem_addr == pend_addr, "R7 addr held", mem_addr, pend_addr);
            if (cnt >= lat) begin
                mem_valid <= 1'b1;
                mem_rdata <= memf(mem_addr);
                pend = 0;
                cnt = 0;
                if (exp_rd_addr.size() == 0)
                    check(0, "R2/R3 unexpected read", mem_addr, 0);
                else begin
                    logic [15:0] ea_exp;
                    ea_exp = exp_rd_addr.pop_front();
                    check(mem_addr == ea_exp, exp_tag[0], mem_addr, ea_exp);
                end
            end else begin
                pend = 1;
                pend_addr = mem_addr;
                cnt++;
            end
        end else if (rst_n && pend) begin
            check(0, "R7 req dropped", 0, 1);
            pend = 0;
        end
    end

    // write monitor and done check (R6 R8)
    bit want_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (want_done) begin
                check(done && !wr_en, "R8 done after write", {done, wr_en}, 2'b10);
                want_done = 0;
            end else if (done) check(0, "R8 stray done", 1, 0);
            if (wr_en) begin
                want_done = 1;
                if (exp_wr.size() == 0) check(0, "R9 extra write", {wr_dst, wr_data}, 0);
                else begin
                    logic [18:0] e;
                    e = exp_wr.pop_front();
                    check({wr_dst, wr_data} == e, exp_tag[0], {wr_dst, wr_data}, e);
                    void'(exp_tag.pop_front());
                end
            end
        end
    end

    // driver
    task automatic run_op(input logic [1:0] m, input logic [15:0] p, input logic [15:0] ins,
                          input logic [15:0] b, input int l, input string tag, input bit poke);
        logic [15:0] a1, d;
        a1 = {p[15:9], ins[8:0]};
        lat = l;
        case (m)
            2'd0: d = a1;
            2'd1: begin exp_rd_addr.push_back(a1); d = memf(a1); end
            2'd2: begin exp_rd_addr.push_back(a1); exp_rd_addr.push_back(memf(a1)); d = memf(memf(a1)); end
            default: begin
                a1 = b + {10'd0, ins[5:0]};
                exp_rd_addr.push_back(a1); d = memf(a1);
            end
        endcase
        exp_wr.push_back({ins[11:9], d});
        exp_tag.push_back(tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        mode = m; pc = p; instr = ins; base_val = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            mode = 2'd2; pc = 16'h1234; instr = 16'hFFFF; base_val = 16'h7777; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_wr.size() == 0 && exp_rd_addr.size() == 0 && !busy, {tag, " complete"},
              {exp_wr.size(), exp_rd_addr.size()}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !wr_en && !done, "R1 reset outputs",
              {busy, mem_req, wr_en, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_req && !wr_en && !done, "R1 idle after reset",
              {busy, mem_req, wr_en, done}, 0);
        run_op(2'd0, 16'hA3F1, 16'h0BC4, 16'h0, 0, "R2 page form", 0);
        run_op(2'd0, 16'h01FF, 16'h01FF, 16'h0, 0, "R2 page offset max", 0);
        run_op(2'd1, 16'h5E02, 16'h0610, 16'h0, 0, "R3 direct lat0", 0);
        run_op(2'd1, 16'hFFFF, 16'h0E00, 16'h0, 3, "R3 direct lat3", 0);
        run_op(2'd2, 16'h2400, 16'h0A55, 16'h0, 1, "R4 indirect lat1", 0);
        run_op(2'd2, 16'h8001, 16'h0001, 16'h0, 4, "R4 indirect lat4", 0);
        run_op(2'd3, 16'h0000, 16'h023F, 16'hFFF0, 0, "R5 base wrap", 0);
        run_op(2'd3, 16'h0000, 16'h0E20, 16'h1000, 2, "R5 index bit5 zero ext", 0);
        run_op(2'd1, 16'h3000, 16'h0C07, 16'h0, 0, "R6 dst 6", 0);
        run_op(2'd3, 16'h0000, 16'h0000, 16'h4321, 0, "R6 dst 0", 0);
        run_op(2'd1, 16'h7200, 16'h0812, 16'h0, 2, "R9 start while busy", 1);
        run_op(2'd0, 16'h6600, 16'h0433, 16'h0, 0, "R9 page while busy", 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule